// File: doc/BRIEF.md
# Thermal Sensor Control Word Decoder

This block sits in the system clock domain of a thermal camera channel. Software writes a 32-bit control word over a simple write strobe. The block turns each word into held control levels for the sensor: reset, power-down, master-clock enable, SPI reset and enable, acceptance of segment number zero, store-to-memory enable, SPI clock mode, and four GPIO pins, each with its own output enable. Each held level sits next to its own update bit. A level moves only when that update bit is written as 1, so one write can change any subset of fields and leave the others as they were.

Two bits of the word do not hold a level. Each one produces a pulse of a single cycle: one requests the capture of a single frame, and the other clears a sticky CRC error flag elsewhere in the channel.

The block also makes the sensor master clock. A down-counter divides the system clock, and the master-clock enable gates it. When the enable is taken away, the divider finishes the high phase it is in. The clock then stops low, so no shortened pulse reaches the sensor. Pad buffers and the crossing into the pixel clock domain belong to the surrounding logic.

Top module: `thermal_ctl_decoder`

## Requirements
- R1: While `rst_n` is low, every held output is 0. The sensor reset and power-down outputs are therefore active (low), the master clock is disabled, all enables are off, and all GPIOs are inputs (`gpio_oe` = 0). `sns_mclk`, `frame_single` and `crc_clear` are also 0.
- R2: Bit 0 is the reset level and bit 1 is its update bit. Bits 2 and 3 do the same for power-down, and bits 4 and 5 for master-clock enable. On the clock edge that captures a write, a level whose update bit is 1 takes its value bit.
- R3: Bits 8 and 9 are the segment-zero acceptance value and its update bit. Bits 10 and 11 do the same for store enable, and bits 14 and 15 for the SPI clock mode (1 means free-running). All use the same value-plus-update rule as R2.
- R4: Bits 7:6 carry the SPI code. Code 0 changes nothing. Code 1 sets `spi_nrst` = 0 and `spi_en` = 0. Code 2 sets `spi_nrst` = 1 and `spi_en` = 0. Code 3 sets both to 1.
- R5: Pin n takes a 2-bit code from bits 17+2n:16+2n. Code 0 changes nothing. Code 1 drives the pin low (`gpio_out`[n] = 0, `gpio_oe`[n] = 1). Code 2 drives it high (`gpio_out`[n] = 1, `gpio_oe`[n] = 1). Code 3 turns the pin into an input (`gpio_oe`[n] = 0, `gpio_out`[n] kept).
- R6: A write with bit 12 set makes `frame_single` high for exactly the one cycle after the capture edge. Bit 13 does the same for `crc_clear`. With no write, both outputs are 0.
- R7: A write whose update bits are 0 and whose codes are 0 leaves every held output unchanged, whatever its value bits are. Cycles with no write also leave every held output unchanged.
- R8: While the master clock is enabled, `sns_mclk` stays high for HALFDIV cycles and then low for HALFDIV cycles, repeating.
- R9: Every high phase of `sns_mclk` lasts exactly HALFDIV cycles, including the one in progress when the enable is removed. Once the enable is off and the clock is low, `sns_mclk` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word |
| sns_rst_n | output | 1 | Sensor reset level (0 = reset active) |
| sns_pwdn_n | output | 1 | Sensor power-down level (0 = powered down) |
| mclk_en | output | 1 | Master-clock enable |
| spi_nrst | output | 1 | SPI receiver out of reset |
| spi_en | output | 1 | SPI receiver enabled |
| seg0_accept | output | 1 | Accept segment number zero |
| store_en | output | 1 | Sensor data to memory enable |
| spi_clk_free | output | 1 | 1 = SPI clock free-running, 0 = only during chip select |
| gpio_out | output | 4 | GPIO output levels |
| gpio_oe | output | 4 | GPIO output enables |
| frame_single | output | 1 | One-cycle single-frame request |
| crc_clear | output | 1 | One-cycle CRC error clear |
| sns_mclk | output | 1 | Divided, gated sensor master clock |

## Verification
A write that turns off the master-clock enable can land on the same cycle in which the divider reaches its terminal count and is about to toggle. The bench provokes this by sweeping the disable write across every phase offset of a full divider period, on top of random writes that flip the enable at arbitrary times. Each high phase is then judged to last exactly HALFDIV cycles, and the clock must settle low and stay low. The pulses and the held fields can also come from the same word; every write compares both against a bench model.

// File: rtl/thermctl_pkg.sv
// Package: field positions and code values shared by the control word decoder.
// Assumes the bit layout of the control word is fixed by software.
package thermctl_pkg;

    localparam int POS_RST    = 0;   // value bit, update bit is +1
    localparam int POS_PWDN   = 2;
    localparam int POS_MCLK   = 4;
    localparam int POS_SPI    = 6;   // 2-bit code
    localparam int POS_SEG0   = 8;
    localparam int POS_STORE  = 10;
    localparam int POS_SINGLE = 12;  // pulse
    localparam int POS_CRCCLR = 13;  // pulse
    localparam int POS_SPICLK = 14;
    localparam int POS_GPIO   = 16;  // 2 bits per pin

    localparam int HELD_COUNT = 6;

    typedef enum logic [1:0] {
        SPI_KEEP    = 2'd0,
        SPI_HOLD    = 2'd1,
        SPI_IDLE    = 2'd2,
        SPI_RUN     = 2'd3
    } spi_code_e;

    typedef enum logic [1:0] {
        PIN_KEEP  = 2'd0,
        PIN_LOW   = 2'd1,
        PIN_HIGH  = 2'd2,
        PIN_FLOAT = 2'd3
    } pin_code_e;

    // Value-bit position of held level number idx (its update bit is one above).
    function automatic int held_pos(input int idx);
        case (idx)
            0:       return POS_RST;
            1:       return POS_PWDN;
            2:       return POS_MCLK;
            3:       return POS_SEG0;
            4:       return POS_STORE;
            default: return POS_SPICLK;
        endcase
    endfunction

endpackage

// File: rtl/tc_held_bit.sv
// Module: one held level with its own update bit.
// Assumes the value and the update bit come from the same write word.
module tc_held_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic val,
    input  logic upd,
    output logic q
);

    // Load the value when a write carries the update bit; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (wr_en && upd)
            q <= val;
    end

endmodule

// File: rtl/tc_gpio_pin.sv
// Module: one GPIO pin driven by a 2-bit code (keep, low, high, input).
// Assumes reset leaves the pin as an input with a low output level.
module tc_gpio_pin
    import thermctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] code,
    output logic       pin_out,
    output logic       pin_oe
);

    pin_code_e code_e;
    assign code_e = pin_code_e'(code);

    // Apply the pin code on a write; the input code keeps the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out <= 1'b0;
            pin_oe  <= 1'b0;
        end else if (wr_en) begin
            case (code_e)
                PIN_LOW:   begin pin_out <= 1'b0; pin_oe <= 1'b1; end
                PIN_HIGH:  begin pin_out <= 1'b1; pin_oe <= 1'b1; end
                PIN_FLOAT: pin_oe <= 1'b0;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/tc_mclk_div.sv
// Module: gated clock divider; output toggles every HALFDIV system cycles.
// Assumes HALFDIV >= 1. After the enable drops, the divider runs until the
// output is low and then parks with the counter frozen.
module tc_mclk_div #(
    parameter int HALFDIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic clk_out
);

    localparam int CNT_W = (HALFDIV > 1) ? $clog2(HALFDIV) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HALFDIV - 1);

    logic [CNT_W-1:0] cnt;

    // Count down; at zero reload and toggle, allowing a rise only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= RELOAD;
            clk_out <= 1'b0;
        end else if (cnt == '0) begin
            cnt     <= RELOAD;
            clk_out <= en && !clk_out;
        end else if (en || clk_out) begin
            cnt     <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/thermal_ctl_decoder.sv
// Module: decodes a written control word into held sensor control levels,
// one-cycle request pulses, and a gated divided master clock.
// Assumes a single clock domain and a synchronous active-low reset.
module thermal_ctl_decoder
    import thermctl_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int NUM_GPIO = 4,
    parameter int HALFDIV  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    output logic                sns_rst_n,
    output logic                sns_pwdn_n,
    output logic                mclk_en,
    output logic                spi_nrst,
    output logic                spi_en,
    output logic                seg0_accept,
    output logic                store_en,
    output logic                spi_clk_free,
    output logic [NUM_GPIO-1:0] gpio_out,
    output logic [NUM_GPIO-1:0] gpio_oe,
    output logic                frame_single,
    output logic                crc_clear,
    output logic                sns_mclk
);

    localparam int GPIO_END = POS_GPIO + 2 * NUM_GPIO;

    logic [HELD_COUNT-1:0] held_q;
    spi_code_e             spi_code;

    // Bits above the GPIO fields carry nothing.
    logic unused_high;
    assign unused_high = ^wr_data[WORD_W-1:GPIO_END];

    // One value-plus-update register per held level.
    for (genvar i = 0; i < HELD_COUNT; i++) begin : g_held
        tc_held_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en),
            .val   (wr_data[held_pos(i)]),
            .upd   (wr_data[held_pos(i) + 1]),
            .q     (held_q[i])
        );
    end

    assign sns_rst_n    = held_q[0];
    assign sns_pwdn_n   = held_q[1];
    assign mclk_en      = held_q[2];
    assign seg0_accept  = held_q[3];
    assign store_en     = held_q[4];
    assign spi_clk_free = held_q[5];

    assign spi_code = spi_code_e'(wr_data[POS_SPI +: 2]);

    // SPI reset/enable pair from its 2-bit code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spi_nrst <= 1'b0;
            spi_en   <= 1'b0;
        end else if (wr_en) begin
            case (spi_code)
                SPI_HOLD: begin spi_nrst <= 1'b0; spi_en <= 1'b0; end
                SPI_IDLE: begin spi_nrst <= 1'b1; spi_en <= 1'b0; end
                SPI_RUN:  begin spi_nrst <= 1'b1; spi_en <= 1'b1; end
                default:  ;
            endcase
        end
    end

    // One code-driven register pair per GPIO pin.
    for (genvar g = 0; g < NUM_GPIO; g++) begin : g_pin
        tc_gpio_pin u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .code    (wr_data[POS_GPIO + 2 * g +: 2]),
            .pin_out (gpio_out[g]),
            .pin_oe  (gpio_oe[g])
        );
    end

    // Single-cycle request pulses, registered from the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_single <= 1'b0;
            crc_clear    <= 1'b0;
        end else begin
            frame_single <= wr_en && wr_data[POS_SINGLE];
            crc_clear    <= wr_en && wr_data[POS_CRCCLR];
        end
    end

    tc_mclk_div #(
        .HALFDIV (HALFDIV)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (mclk_en),
        .clk_out (sns_mclk)
    );

endmodule

// File: rtl/tc_ctl_checker.sv
// Module: assertion checker for thermal_ctl_decoder, bound to every instance.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module tc_ctl_checker #(
    parameter int NUM_GPIO = 4,
    parameter int HALFDIV  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [31:0]         wr_data,
    input logic                sns_rst_n,
    input logic                sns_pwdn_n,
    input logic                mclk_en,
    input logic                spi_nrst,
    input logic                spi_en,
    input logic                seg0_accept,
    input logic                store_en,
    input logic                spi_clk_free,
    input logic [NUM_GPIO-1:0] gpio_out,
    input logic [NUM_GPIO-1:0] gpio_oe,
    input logic                frame_single,
    input logic                crc_clear,
    input logic                sns_mclk
);

    logic [7+2*NUM_GPIO:0] held;
    assign held = {sns_rst_n, sns_pwdn_n, mclk_en, seg0_accept, store_en,
                   spi_clk_free, spi_nrst, spi_en, gpio_out, gpio_oe};

    int hi_run;

    // Length of the current high phase of the master clock.
    always_ff @(posedge clk) begin
        if (!rst_n)        hi_run <= 0;
        else if (sns_mclk) hi_run <= hi_run + 1;
        else               hi_run <= 0;
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (held == '0 && !sns_mclk && !frame_single && !crc_clear)); // R1
    AST_RST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[1]) |=> (sns_rst_n == $past(wr_data[0]))); // R2
    AST_SEG0_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[9]) |=> (seg0_accept == $past(wr_data[8]))); // R3
    AST_SPI_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7:6] == 2'd3) |=> (spi_nrst && spi_en)); // R4
    AST_GPIO_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[17:16] == 2'd3) |=> !gpio_oe[0]); // R5
    AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!frame_single && !crc_clear)); // R6
    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(held)); // R7
    AST_NOSET_PWDN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[3]) |=> $stable(sns_pwdn_n)); // R7
    AST_MCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!mclk_en && !sns_mclk) |=> !sns_mclk); // R9
    AST_MCLK_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sns_mclk) |-> (hi_run == HALFDIV)); // R9

endmodule

bind thermal_ctl_decoder tc_ctl_checker #(
    .NUM_GPIO (NUM_GPIO),
    .HALFDIV  (HALFDIV)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .sns_rst_n    (sns_rst_n),
    .sns_pwdn_n   (sns_pwdn_n),
    .mclk_en      (mclk_en),
    .spi_nrst     (spi_nrst),
    .spi_en       (spi_en),
    .seg0_accept  (seg0_accept),
    .store_en     (store_en),
    .spi_clk_free (spi_clk_free),
    .gpio_out     (gpio_out),
    .gpio_oe      (gpio_oe),
    .frame_single (frame_single),
    .crc_clear    (crc_clear),
    .sns_mclk     (sns_mclk)
);

// File: tb/thermal_ctl_decoder_tb.sv
// Bench: random and directed control words against a bench model of the fields.
module thermal_ctl_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALFDIV    = 4;
    localparam int NUM_GPIO   = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        sns_rst_n, sns_pwdn_n, mclk_en, spi_nrst, spi_en;
    logic        seg0_accept, store_en, spi_clk_free;
    logic [3:0]  gpio_out, gpio_oe;
    logic        frame_single, crc_clear, sns_mclk;

    int          checks = 0;
    int          errors = 0;
    int          hi_run = 0;
    bit          done = 0;
    logic [15:0] exp_st;
    logic [15:0] act;

    always #(CLK_PERIOD / 2) clk = ~clk;

    thermal_ctl_decoder #(
        .WORD_W   (32),
        .NUM_GPIO (NUM_GPIO),
        .HALFDIV  (HALFDIV)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .sns_rst_n    (sns_rst_n),
        .sns_pwdn_n   (sns_pwdn_n),
        .mclk_en      (mclk_en),
        .spi_nrst     (spi_nrst),
        .spi_en       (spi_en),
        .seg0_accept  (seg0_accept),
        .store_en     (store_en),
        .spi_clk_free (spi_clk_free),
        .gpio_out     (gpio_out),
        .gpio_oe      (gpio_oe),
        .frame_single (frame_single),
        .crc_clear    (crc_clear),
        .sns_mclk     (sns_mclk)
    );

    // Layout: 15 rst, 14 pwdn, 13 mclk, 12 seg0, 11 store, 10 spiclk, 9 nrst, 8 en, 7:4 out, 3:0 oe.
    assign act = {sns_rst_n, sns_pwdn_n, mclk_en, seg0_accept, store_en,
                  spi_clk_free, spi_nrst, spi_en, gpio_out, gpio_oe};

    // Expected held state after one write, from the requirements.
    function automatic logic [15:0] step(input logic [15:0] s, input logic [31:0] w);
        logic [15:0] n;
        n = s;
        if (w[1])  n[15] = w[0];
        if (w[3])  n[14] = w[2];
        if (w[5])  n[13] = w[4];
        if (w[9])  n[12] = w[8];
        if (w[11]) n[11] = w[10];
        if (w[15]) n[10] = w[14];
        case (w[7:6])
            2'd1:    n[9:8] = 2'b00;
            2'd2:    n[9:8] = 2'b10;
            2'd3:    n[9:8] = 2'b11;
            default: ;
        endcase
        for (int g = 0; g < 4; g++) begin
            case (w[16 + 2 * g +: 2])
                2'd1:    begin n[4 + g] = 1'b0; n[g] = 1'b1; end
                2'd2:    begin n[4 + g] = 1'b1; n[g] = 1'b1; end
                2'd3:    n[g] = 1'b0;
                default: ;
            endcase
        end
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, a, e);
        end
    endtask

    task automatic check_state();
        chk(act[15:13] == exp_st[15:13], "R2 reset/pwdn/mclk levels", 32'(act[15:13]), 32'(exp_st[15:13]));
        chk(act[12:10] == exp_st[12:10], "R3 seg0/store/spiclk levels", 32'(act[12:10]), 32'(exp_st[12:10]));
        chk(act[9:8] == exp_st[9:8], "R4 spi code", 32'(act[9:8]), 32'(exp_st[9:8]));
        chk(act[7:0] == exp_st[7:0], "R5 gpio codes", 32'(act[7:0]), 32'(exp_st[7:0]));
    endtask

    // Called just after a negedge; checks one negedge after the capture edge.
    task automatic do_write(input logic [31:0] w);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
        exp_st  = step(exp_st, w);
        check_state();
        chk(frame_single == w[12], "R6 single pulse", 32'(frame_single), 32'(w[12]));
        chk(crc_clear == w[13], "R6 crc clear pulse", 32'(crc_clear), 32'(w[13]));
    endtask

    task automatic idle();
        @(negedge clk);
        chk(act == exp_st, "R7 hold without write", 32'(act), 32'(exp_st));
        chk(!frame_single && !crc_clear, "R6 pulse lasts one cycle",
            32'({frame_single, crc_clear}), 32'd0);
    endtask

    // Monitor: every completed high phase of the master clock is full length.
    always @(negedge clk) begin
        if (!rst_n) hi_run = 0;
        else if (sns_mclk) hi_run++;
        else if (hi_run != 0) begin
            chk(hi_run == HALFDIV, "R9 high phase length", 32'(hi_run), 32'(HALFDIV));
            hi_run = 0;
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-R actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int hi, lo, guard, hits;
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_data = '0;
        exp_st  = '0;
        repeat (3) @(negedge clk);
        chk(act == 16'h0 && !sns_mclk && !frame_single && !crc_clear, "R1 reset state",
            32'({act, sns_mclk, frame_single, crc_clear}), 32'd0);
        wr_en = 1'b1;
        wr_data = 32'h00AA_FFFF;   // writes during reset are ignored
        @(negedge clk);
        wr_en = 1'b0;
        chk(act == 16'h0, "R1 reset dominates write", 32'(act), 32'd0);
        rst_n = 1'b1;
        idle();

        // R7: value bits without update bits, and all-zero codes.
        do_write(32'h0000_4515);
        do_write(32'h0000_0000);
        // Everything on, both pulses, all pins high.
        do_write(32'h00AA_FFFF);
        idle();
        // R5: mixed pin codes: pin0 low, pin1 input, pin2 keep, pin3 high.
        do_write(32'h008D_0000);
        // R4: SPI codes 1 and 2, then 3.
        do_write(32'h0000_0040);
        do_write(32'h0000_0080);
        do_write(32'h0000_00C0);
        // R2: clear reset and power-down levels via update bits only.
        do_write(32'h0000_000A);
        idle();

        // Random writes with a fixed seed.
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < 400; k++) begin
            do_write($urandom());
            if ($urandom_range(1, 0) == 1) idle();
        end

        // R8: measure one full period while enabled.
        do_write(32'h0000_0030);
        guard = 0;
        while (sns_mclk && guard < 100) begin @(negedge clk); guard++; end
        while (!sns_mclk && guard < 100) begin @(negedge clk); guard++; end
        hi = 0;
        while (sns_mclk && hi < 100) begin hi++; @(negedge clk); end
        lo = 0;
        while (!sns_mclk && lo < 100) begin lo++; @(negedge clk); end
        chk(hi == HALFDIV, "R8 high phase while enabled", 32'(hi), 32'(HALFDIV));
        chk(lo == HALFDIV, "R8 low phase while enabled", 32'(lo), 32'(HALFDIV));

        // R9: remove the enable at every phase offset of a period.
        for (int p = 0; p < 2 * HALFDIV; p++) begin
            do_write(32'h0000_0030);
            repeat (3 * HALFDIV + p) idle();
            do_write(32'h0000_0020);
            repeat (2 * HALFDIV + 2) idle();
            hits = 0;
            repeat (20) begin
                idle();
                if (sns_mclk) hits++;
            end
            chk(hits == 0, "R9 clock parked low", 32'(hits), 32'd0);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule